// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block turns a single asynchronous serial line into characters and gives each completed character to a host through a one-byte receive data register. It is paced by a single-cycle enable that pulses sixteen times per bit period. The line is first brought into the clock domain by a short synchronizer. A falling edge is then accepted as a start bit only if the line is still low half a bit later. After that, every data bit, the optional parity bit and the stop bit are sampled at the centre of their bit periods.

The character length is programmable from five to eight bits, and the least significant bit arrives first. Parity can be switched off or set to even or odd. A four-bit status word reports receiver-full, overrun, framing error and parity error. A read strobe on the data register clears all four flags. The receiver interrupt output follows the full flag when it is enabled. When echo is enabled, the transmit output copies the raw serial input.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset the status word is 0, the data register is 0, the interrupt output is low and the transmit output is high while echo is off.
- R2: A low pulse on the line that is shorter than half a bit period (eight ticks) does not start a character: the status stays 0, and a character that follows is received correctly.
- R3: The character length is 5, 6, 7 or 8 bits for a length code of 0, 1, 2 or 3. Bits arrive least significant first, and data bits above the programmed length read as 0.
- R4: With parity enabled, the parity flag (status bit 0) is set when the total count of ones in the data bits and the parity bit is odd under even parity (odd-select 0), or even under odd parity (odd-select 1). With parity disabled, the flag is never set and no parity bit is expected.
- R5: The framing flag (status bit 1) is set when the stop bit is sampled low.
- R6: When a character completes while the register is empty, the data register loads that character and the full flag (status bit 3) is set.
- R7: When a character completes while the full flag is set, the overrun flag (status bit 2) is set and the data register and the other flags keep their previous values.
- R8: A read strobe clears the full, overrun, framing and parity flags on the next cycle.
- R9: The interrupt output is high exactly when the interrupt enable and the full flag are both high.
- R10: With echo enabled, the transmit output equals the serial input in the same cycle. With echo disabled, it is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16_i | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| wlen_i | input | 2 | Length code: 0..3 selects 5..8 bits |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| echo_en_i | input | 1 | Loop serial input to transmit output |
| irq_en_i | input | 1 | Receiver interrupt enable |
| rd_i | input | 1 | Read strobe of the data register |
| rx_data_o | output | 8 | Receive data register |
| status_o | output | 4 | {full, overrun, framing, parity} |
| irq_o | output | 1 | Receiver interrupt |
| txd_o | output | 1 | Transmit output used by echo |

## Verification
The checker properties assume that a read strobe does not land in the same cycle as a character completing, unless the read is meant to win and reload. The upper-bit check assumes the length code is not changed while the full flag rises. The bench keeps the length, parity and echo settings stable for the whole of each character. It issues read strobes only during line idle time, after a character has fully completed. It also drives exactly sixteen ticks per bit, so that mid-bit samples stay well inside each bit period.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int OVS      = 16;
    localparam int HALF     = OVS / 2;
    localparam int CNT_W    = $clog2(OVS);
    localparam int DATA_W   = 8;
    localparam int IDX_W    = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_odd;
    } rx_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_char_t;

    typedef struct packed {
        logic full;
        logic ovr;
        logic frm;
        logic par;
    } rx_stat_t;

    function automatic logic [IDX_W:0] bits_of(input logic [1:0] code);
        return (IDX_W+1)'(5) + {{(IDX_W-1){1'b0}}, code};
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] code);
        return {DATA_W{1'b1}} >> (2'd3 - code);
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
    import serial_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  logic     rxd_i,
    input  rx_cfg_t  cfg_i,
    output logic     done_o,
    output rx_char_t char_o
);
    rx_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  shreg;
    logic               par_acc;
    logic               mid_bit;
    logic               last_bit;

    assign mid_bit  = (cnt == CNT_W'(OVS-1));
    assign last_bit = ({1'b0, idx} == bits_of(cfg_i.wlen) - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
        end else if (tick_i) begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (!rxd_i) state <= ST_START;
                end
                ST_START: begin
                    if (cnt == CNT_W'(HALF-1)) begin
                        cnt <= '0;
                        if (!rxd_i) begin
                            state   <= ST_DATA;
                            idx     <= '0;
                            shreg   <= '0;
                            par_acc <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (mid_bit) begin
                        cnt        <= '0;
                        shreg[idx] <= rxd_i;
                        par_acc    <= par_acc ^ rxd_i;
                        if (last_bit)
                            state <= cfg_i.par_en ? ST_PARITY : ST_STOP;
                        else
                            idx <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (mid_bit) begin
                        cnt     <= '0;
                        par_acc <= par_acc ^ rxd_i;
                        state   <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (mid_bit) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done_o         = tick_i && (state == ST_STOP) && mid_bit;
    assign char_o.data    = shreg;
    assign char_o.frm_err = !rxd_i;
    assign char_o.par_err = cfg_i.par_en && (par_acc ^ cfg_i.par_odd);
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  rx_char_t          char_i,
    input  logic [1:0]        wlen_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output rx_stat_t          stat_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            stat_o <= '0;
        end else if (done_i && stat_o.full && !rd_i) begin
            stat_o.ovr <= 1'b1;
        end else if (done_i) begin
            data_o       <= char_i.data & width_mask(wlen_i);
            stat_o.full  <= 1'b1;
            stat_o.ovr   <= 1'b0;
            stat_o.frm   <= char_i.frm_err;
            stat_o.par   <= char_i.par_err;
        end else if (rd_i) begin
            stat_o <= '0;
        end
    end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick16_i,
    input  logic        rxd_i,
    input  logic [1:0]  wlen_i,
    input  logic        par_en_i,
    input  logic        par_odd_i,
    input  logic        echo_en_i,
    input  logic        irq_en_i,
    input  logic        rd_i,
    output logic [7:0]  rx_data_o,
    output logic [3:0]  status_o,
    output logic        irq_o,
    output logic        txd_o
);
    logic     rxd_s;
    logic     char_done;
    rx_char_t char_w;
    rx_cfg_t  cfg;
    rx_stat_t stat;

    assign cfg = '{wlen: wlen_i, par_en: par_en_i, par_odd: par_odd_i};

    serial_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rxd_i),
        .q_o (rxd_s)
    );

    serial_rx_framer i_framer (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick16_i),
        .rxd_i  (rxd_s),
        .cfg_i  (cfg),
        .done_o (char_done),
        .char_o (char_w)
    );

    serial_rx_status i_status (
        .clk    (clk),
        .rst    (rst),
        .done_i (char_done),
        .char_i (char_w),
        .wlen_i (wlen_i),
        .rd_i   (rd_i),
        .data_o (rx_data_o),
        .stat_o (stat)
    );

    assign status_o = stat;
    assign irq_o    = irq_en_i & stat.full;
    assign txd_o    = echo_en_i ? rxd_i : 1'b1;
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd_i,
    input logic [1:0] wlen_i,
    input logic [3:0] status_o,
    input logic [7:0] rx_data_o,
    input logic       char_done
);
    // R8: a read strobe without a completing character empties the status
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !char_done) |=> (status_o == 4'b0000));

    // R7: a full register keeps its data until it is read
    a_r7_data_kept: assert property (@(posedge clk) disable iff (rst)
        (status_o[3] && !rd_i) |=> $stable(rx_data_o));

    // R7: a character arriving on a full register raises overrun
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (status_o[3] && char_done && !rd_i) |=> status_o[2]);

    // R7: overrun is only ever seen together with full
    a_r7_ovr_with_full: assert property (@(posedge clk) disable iff (rst)
        status_o[2] |-> status_o[3]);

    // R5: a framing flag only appears along with a loaded character
    a_r5_frame_loads: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[1]) |-> status_o[3]);

    // R3: five-bit characters leave the upper three bits clear
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        ($rose(status_o[3]) && ($past(wlen_i) == 2'd0)) |-> (rx_data_o[7:5] == 3'b000));
endmodule

bind serial_rx_unit serial_rx_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_i      (rd_i),
    .wlen_i    (wlen_i),
    .status_o  (status_o),
    .rx_data_o (rx_data_o),
    .char_done (char_done)
);

// File: tb/test_serial_rx_unit.sv
module test_serial_rx_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] wlen = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       echo_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rx_data;
    logic [3:0] status;
    logic       irq;
    logic       txd;

    int n_chk = 0;
    int n_bad = 0;
    int tdiv  = 0;
    localparam int CLK_PER_BIT = 64;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
        tick16 <= (tdiv == 3);
    end

    serial_rx_unit i_serial_rx_unit (
        .clk(clk), .rst(rst), .tick16_i(tick16), .rxd_i(rxd),
        .wlen_i(wlen), .par_en_i(par_en), .par_odd_i(par_odd),
        .echo_en_i(echo_en), .irq_en_i(irq_en), .rd_i(rd),
        .rx_data_o(rx_data), .status_o(status), .irq_o(irq), .txd_o(txd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input logic [1:0] w);
        return 8'hFF >> (3 - w);
    endfunction

    function automatic logic [3:0] exp_stat(input logic pe_on, input logic bad_par, input logic bad_stop);
        return {1'b1, 1'b0, bad_stop, pe_on & bad_par};
    endfunction

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (CLK_PER_BIT) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        logic [7:0] m;
        logic p;
        m = d & mask_of(wlen);
        p = (^m) ^ par_odd ^ bad_par;
        hold_bit(1'b0);
        for (int i = 0; i < 5 + wlen; i++) hold_bit(d[i]);
        if (par_en) hold_bit(p);
        hold_bit(!bad_stop);
        hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    task automatic read_reg();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [7:0] d;
        logic [7:0] first;
        logic bp;
        logic bs;
        void'($urandom(32'd1234));
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 status", status, 4'h0);
        check("R1 data", rx_data, 8'h00);
        check("R1 irq", irq, 1'b0);
        check("R1 txd", txd, 1'b1);

        // R2: short glitch of three ticks
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * CLK_PER_BIT) @(negedge clk);
        check("R2 glitch ignored", status, 4'h0);

        // R6 / R3: 8-bit directed
        wlen = 2'd3; par_en = 1'b0;
        send(8'hA5, 1'b0, 1'b0);
        check("R6 data", rx_data, 8'hA5);
        check("R6 full", status, 4'h8);
        // R9: interrupt follows enable and full
        check("R9 irq off", irq, 1'b0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R9 irq on", irq, 1'b1);
        read_reg();
        check("R8 cleared", status, 4'h0);
        check("R9 irq after read", irq, 1'b0);
        irq_en = 1'b0;

        // R3: 5-bit with upper bits of the sent byte set
        wlen = 2'd0;
        send(8'hF6, 1'b0, 1'b0);
        check("R3 5-bit data", rx_data, 8'h16);
        read_reg();

        // R4: odd parity error, even parity good
        wlen = 2'd2; par_en = 1'b1; par_odd = 1'b1;
        send(8'h3C, 1'b1, 1'b0);
        check("R4 odd parity err", status, 4'h9);
        read_reg();
        par_odd = 1'b0;
        send(8'h51, 1'b0, 1'b0);
        check("R4 even parity ok", status, 4'h8);
        check("R4 data", rx_data, 8'h51);
        read_reg();

        // R5: framing error
        par_en = 1'b0; wlen = 2'd3;
        send(8'h0F, 1'b0, 1'b1);
        check("R5 frame flag", status, 4'hA);
        read_reg();
        check("R8 clear frame", status, 4'h0);

        // R7: overrun keeps first character
        send(8'h11, 1'b0, 1'b0);
        first = rx_data;
        send(8'h22, 1'b0, 1'b0);
        check("R7 data kept", rx_data, 8'h11);
        check("R7 overrun", status, 4'hC);
        check("R7 first ok", first, 8'h11);
        read_reg();
        check("R8 clear overrun", status, 4'h0);

        // R10: echo
        echo_en = 1'b1;
        rxd = 1'b0;
        #1;
        check("R10 echo low", txd, 1'b0);
        rxd = 1'b1;
        #1;
        check("R10 echo high", txd, 1'b1);
        echo_en = 1'b0;
        rxd = 1'b0;
        #1;
        check("R10 echo off", txd, 1'b1);
        rxd = 1'b1;
        repeat (3 * CLK_PER_BIT) @(negedge clk);
        check("R2 no stray frame", status, 4'h0);

        // random frames: R3 R4 R5 R6 R8
        for (int k = 0; k < 20; k++) begin
            wlen    = 2'($urandom_range(0, 3));
            par_en  = 1'($urandom_range(0, 1));
            par_odd = 1'($urandom_range(0, 1));
            d       = 8'($urandom);
            bp      = ($urandom_range(0, 3) == 0);
            bs      = ($urandom_range(0, 4) == 0);
            send(d, bp, bs);
            check("R3 rand data", rx_data, d & mask_of(wlen));
            check("R4 R5 R6 rand status", status, exp_stat(par_en, bp, bs));
            read_reg();
            check("R8 rand clear", status, 4'h0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule